// File: doc/BRIEF.md
# Five-State Sequencing Controller

This block is a small synchronous control machine that moves through five binary-coded states. Two single-bit inputs steer it. `go_in` selects between advancing and falling back. `park_in` freezes the machine while it sits in its fourth state.

It drives two outputs at once. `mealy_out` is a registered-state-plus-input (Mealy) output, formed combinationally from the present state and the present inputs. `moore_out` depends on the present state alone. The current state code is also brought out on `state_o`, so surrounding logic and a testbench can observe it.

The state register only loads the next state. All next-state and output decisions sit in one combinational case statement that has default assignments. An active-low asynchronous reset forces the idle code at any time, whether or not the clock is running.

Top module: `seq_ctrl5`

## Requirements
- R1: While `rst_n` is low, `state_o` is 000 at once, without waiting for a clock edge, and it stays 000 across clock edges. During reset, `moore_out` is 0.
- R2: In state 000, `park_in` has no effect. With `go_in`=0 the state stays 000 and `mealy_out` is 1. With `go_in`=1 the next state is 001 and `mealy_out` is 0.
- R3: In state 001, `park_in` has no effect. With `go_in`=0 the next state is 000 and `mealy_out` is 0. With `go_in`=1 the next state is 010 and `mealy_out` is 1.
- R4: In state 010, the next state is always 011 and `mealy_out` is 0, whatever the inputs are.
- R5: In state 011 with `park_in`=1, the state stays 011 for as many cycles as `park_in` stays high, whatever `go_in` is. `mealy_out` is 0 during this time.
- R6: In state 011 with `park_in`=0, `mealy_out` is 1. The next state is 100 when `go_in`=1 and 000 when `go_in`=0.
- R7: In state 100, the next state is always 000 and `mealy_out` is 0, whatever the inputs are.
- R8: `moore_out` is 1 exactly in states 011 and 100. It does not change when the inputs change within a cycle.
- R9: `state_o` carries the state as a 3-bit binary code, one of 000, 001, 010, 011 or 100. The codes 101, 110 and 111 never appear after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to state 000 |
| go_in | input | 1 | Advance/fall-back select |
| park_in | input | 1 | Freeze request, honoured only in state 011 |
| state_o | output | 3 | Current state code |
| mealy_out | output | 1 | Output from state and inputs |
| moore_out | output | 1 | Output from state only |

## Verification
In state 011, the freeze request and the advance selection can both be asserted in the same cycle. The bench provokes this by holding `park_in` high for several consecutive cycles while `go_in` toggles between 1 and 0. It judges the result by checking that the state stays 011, that `mealy_out` stays 0 and that `moore_out` stays 1 throughout. Asynchronous reset is also made to land mid-cycle while the machine is in 011. The state must drop to 000 before the next edge.

// File: rtl/seq_ctrl5.sv
module seq_ctrl5 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_in,
  input  logic       park_in,
  output logic [2:0] state_o,
  output logic       mealy_out,
  output logic       moore_out
);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_ARM   = 3'b001,
    ST_STEP  = 3'b010,
    ST_PARK  = 3'b011,
    ST_FIRE  = 3'b100
  } st_t;

  st_t cur_q, nxt;
  logic mealy_c, moore_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= ST_IDLE;
    else        cur_q <= nxt;
  end

  always_comb begin
    nxt     = ST_IDLE;
    mealy_c = 1'b0;
    moore_c = 1'b0;
    case (cur_q)
      ST_IDLE: begin
        nxt     = go_in ? ST_ARM : ST_IDLE;
        mealy_c = ~go_in;
      end
      ST_ARM: begin
        nxt     = go_in ? ST_STEP : ST_IDLE;
        mealy_c = go_in;
      end
      ST_STEP: begin
        nxt = ST_PARK;
      end
      ST_PARK: begin
        moore_c = 1'b1;
        if (park_in) begin
          nxt = ST_PARK;
        end else begin
          nxt     = go_in ? ST_FIRE : ST_IDLE;
          mealy_c = 1'b1;
        end
      end
      ST_FIRE: begin
        moore_c = 1'b1;
        nxt     = ST_IDLE;
      end
      default: begin
        nxt = ST_IDLE;
      end
    endcase
  end

  assign state_o   = cur_q;
  assign mealy_out = mealy_c;
  assign moore_out = moore_c;

endmodule

// File: rtl/seq_ctrl5_chk.sv
module seq_ctrl5_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go_in,
  input logic       park_in,
  input logic [2:0] state_o,
  input logic       mealy_out,
  input logic       moore_out
);

  assert_legal_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4);

  assert_idle_stay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && !go_in) |=> state_o == 3'd0);

  assert_arm_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && !go_in) |=> state_o == 3'd0);

  assert_step_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd2 |=> state_o == 3'd3);

  assert_step_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd2 |-> !mealy_out);

  assert_park_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && park_in) |=> state_o == 3'd3);

  assert_park_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && !park_in && go_in) |=> state_o == 3'd4);

  assert_fire_ret_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd4 |=> state_o == 3'd0);

  assert_moore_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(moore_out) |-> $past(state_o) == 3'd2);

endmodule

bind seq_ctrl5 seq_ctrl5_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go_in(go_in), .park_in(park_in),
  .state_o(state_o), .mealy_out(mealy_out), .moore_out(moore_out)
);

// File: tb/seq_ctrl5_tb.sv
`timescale 1ns/1ps
module seq_ctrl5_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go_in = 1'b0;
  logic       park_in = 1'b0;
  logic [2:0] state_o;
  logic       mealy_out, moore_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seq_ctrl5 u_dut (
    .clk(clk), .rst_n(rst_n), .go_in(go_in), .park_in(park_in),
    .state_o(state_o), .mealy_out(mealy_out), .moore_out(moore_out)
  );

  // {go, park, mealy expected before edge, state expected after edge, moore after edge}
  localparam int NV = 20;
  localparam logic [6:0] VEC [NV] = '{
    7'b00_1_000_0, 7'b10_0_001_0, 7'b00_0_000_0, 7'b10_0_001_0,
    7'b10_1_010_0, 7'b01_0_011_1, 7'b11_0_011_1, 7'b01_0_011_1,
    7'b11_0_011_1, 7'b00_1_000_0, 7'b10_0_001_0, 7'b10_1_010_0,
    7'b10_0_011_1, 7'b10_1_100_1, 7'b11_0_000_0, 7'b01_1_000_0,
    7'b11_0_001_0, 7'b11_1_010_0, 7'b00_0_011_1, 7'b00_1_000_0
  };

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5/R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0] prev;
    // R1: reset state, held across edges with go asserted
    go_in = 1'b1;
    #2;
    check("R1", state_o, 0, "state in reset");
    check("R1", moore_out, 0, "moore in reset");
    @(posedge clk); #2;
    check("R1", state_o, 0, "state across edge in reset");
    go_in = 1'b0;
    #1;
    check("R2", mealy_out, 1, "mealy idle go=0");
    rst_n = 1'b1;
    @(posedge clk); #1;

    prev = 3'd0;
    for (int i = 0; i < NV; i++) begin
      logic [6:0] v;
      v = VEC[i];
      go_in = v[6]; park_in = v[5];
      #1;
      check(req_of(prev), mealy_out, v[4], "mealy");
      check("R8", moore_out, (prev == 3'd3 || prev == 3'd4), "moore steady in cycle");
      @(posedge clk); #1;
      check(req_of(prev), state_o, v[3:1], "next state");
      check("R8", moore_out, v[0], "moore");
      check("R9", state_o <= 3'd4, 1, "legal code");
      prev = state_o;
    end

    // R1: async reset mid-cycle while in 011
    go_in = 1'b1; park_in = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    go_in = 1'b0; park_in = 1'b1;
    @(posedge clk); #1;
    check("R5", state_o, 3, "reach park");
    #1 rst_n = 1'b0;
    #1;
    check("R1", state_o, 0, "async reset mid-cycle");
    check("R1", moore_out, 0, "moore after async reset");
    @(posedge clk); #1;
    check("R1", state_o, 0, "held in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R2", state_o, 0, "idle after release");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule